// File: doc/BRIEF.md
# Deferred Write-Commit Queue for a Multi-Issue Packet

This block holds the architectural side effects of all the instructions in one issue packet until the packet has finished. Each queued item has five fields: a kind (register write, direct PC write or computed PC write), a data value, a register destination, the address of the instruction that produced it, and a forced-write flag. When the packet ends, a commit request drains the queue one item per clock, strictly in the order the items were pushed. The block presents each surviving register write on a write port and shows the producing instruction's address on an attribution port, so that a fault raised by the write can be charged to the right instruction.

During the drain the block selects the branch target. Only the first PC write that survives filtering is used, and every later PC write is dropped. The block also filters the items of an instruction that has a pending imprecise exception recorded against it. Items from other instructions pass unchanged. For a floating-point exception, the faulting instruction's items survive only if its status mask is limited to the benign conditions. For any other exception kind, only its forced items survive. On the final cycle the block drives the PC with the selected target, or with the address captured at commit start if no branch survived. If a link request is pending, the block also writes the captured address to the link register. It then empties the queue.

A packet-start pulse empties the queue and discards any pending exception record. The depth, the data width and the destination width are parameters.

Top module: `wcq_commit_queue`

## Requirements
- R1: After reset, busy, done, reg_we, attr_valid, pc_we, link_we and overflow_err are low and the queue is empty, so a commit issued right after reset completes with no register writes.
- R2: Item kinds are encoded as 0 = register write, 1 = direct PC write, 2 = computed PC write. Surviving register items appear on reg_we/reg_dest/reg_data one per clock in push order. Item i is shown in the i-th cycle after the cycle in which commit_start is sampled (item 0 in the very next cycle).
- R3: Among the PC-write items (kind 1 or 2) that survive filtering, only the first one sets the target. Later PC items are not applied and raise no attribution. At done, pc_out equals the value of that first surviving PC item.
- R4: If no PC item survives, pc_out at done equals pc_in as sampled with commit_start.
- R5: For every applied item (a register write or the winning PC write), attr_valid is high and attr_pc equals that item's instruction address, in the same cycle the item is processed.
- R6: When an exception record is pending, items whose instruction address differs from the recorded address are applied normally.
- R7: For a floating-point record (exc_is_fp = 1), the faulting instruction's items are applied if exc_mask has no bits set other than bit 0 (inexact), bit 1 (underflow) and bit 2 (overflow). Otherwise they are all dropped, and a dropped PC item does not count as the first PC write.
- R8: For a record with exc_is_fp = 0, only the faulting instruction's items with the force flag set are applied.
- R9: A link_req pulse received while idle makes the next commit assert link_we with link_data equal to the captured pc_in in the done cycle. The request is then cleared, so the following commit has no link write.
- R10: With DEPTH items already queued, a further push is dropped and overflow_err is high in the cycle after the push. Pushes into a queue that is not full leave overflow_err low.
- R11: busy rises in the cycle after commit_start is sampled and stays high through done. done is a one-cycle pulse in the cycle after the last item, or in the first cycle if the queue is empty. pc_we is high only with done.
- R12: A pkt_start pulse while idle empties the queue and clears any pending exception record. Items pushed afterwards are applied unfiltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | New packet: empty queue and drop exception record |
| push_valid | input | 1 | Push one item (accepted only while idle) |
| push_kind | input | 2 | Item kind: 0 register, 1 direct PC, 2 computed PC |
| push_value | input | XLEN | Data value or PC target |
| push_dest | input | RW | Register destination |
| push_iaddr | input | XLEN | Address of the producing instruction |
| push_force | input | 1 | Forced-write flag |
| exc_set | input | 1 | Record an imprecise exception |
| exc_is_fp | input | 1 | Recorded exception is floating point |
| exc_iaddr | input | XLEN | Address of the faulting instruction |
| exc_mask | input | 5 | Floating-point status mask |
| link_req | input | 1 | Request a link register update at the next commit |
| commit_start | input | 1 | Begin draining the queue |
| pc_in | input | XLEN | Next packet address, sampled with commit_start |
| overflow_err | output | 1 | Push into a full queue was dropped |
| busy | output | 1 | Commit in progress |
| done | output | 1 | Final cycle of the commit |
| reg_we | output | 1 | Register write strobe |
| reg_dest | output | RW | Register write destination |
| reg_data | output | XLEN | Register write data |
| attr_valid | output | 1 | Attribution address valid |
| attr_pc | output | XLEN | Instruction address of the item being applied |
| pc_we | output | 1 | Final PC write strobe |
| pc_out | output | XLEN | Final PC value |
| link_we | output | 1 | Link register write strobe |
| link_data | output | XLEN | Link register write data |

## Verification
Counting from the cycle in which commit_start is sampled, item i is due on the register and attribution ports i cycles later, starting at 0. done, pc_we and any link write are due N cycles later, where N is the number of queued items. overflow_err is due one cycle after the offending push. The driver computes each expected write and its cycle offset from a model of the requirements and queues it. The monitor samples on the falling edge, measures the offset from a rising-edge cycle counter, and compares each write it sees with the head of the queue, including that offset. An unexpected strobe, or an item still queued after the drain, counts as a miscompare.

// File: rtl/wcq_pkg.sv
package wcq_pkg;
  typedef enum logic [1:0] {
    WK_REG       = 2'd0,
    WK_PC_DIRECT = 2'd1,
    WK_PC_CALC   = 2'd2,
    WK_NONE      = 2'd3
  } wkind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DRAIN = 2'd1,
    SQ_FINAL = 2'd2
  } seq_st_e;

  localparam int FMASK_W = 5;
  // bit0 inexact, bit1 underflow, bit2 overflow; bits above are harmful
  localparam logic [FMASK_W-1:0] FMASK_BENIGN = 5'b00111;
endpackage

// File: rtl/wcq_store.sv
module wcq_store #(
  parameter int DEPTH = 16,
  parameter int XLEN  = 32,
  parameter int RW    = 5,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push_req,
  input  logic [1:0]      push_kind,
  input  logic [XLEN-1:0] push_value,
  input  logic [RW-1:0]   push_dest,
  input  logic [XLEN-1:0] push_iaddr,
  input  logic            push_force,
  input  logic [IW-1:0]   rd_idx,
  output logic [CW-1:0]   count,
  output logic            ovf,
  output logic [1:0]      rd_kind,
  output logic [XLEN-1:0] rd_value,
  output logic [RW-1:0]   rd_dest,
  output logic [XLEN-1:0] rd_iaddr,
  output logic            rd_force
);
  logic [1:0]      kind_q  [DEPTH];
  logic [XLEN-1:0] value_q [DEPTH];
  logic [RW-1:0]   dest_q  [DEPTH];
  logic [XLEN-1:0] iaddr_q [DEPTH];
  logic            force_q [DEPTH];

  logic [CW-1:0] count_q, count_d;
  logic          ovf_q, ovf_d;
  logic          full, accept, count_en;

  always_comb begin
    full     = (count_q == CW'(DEPTH));
    accept   = push_req & ~full;
    ovf_d    = push_req & full;
    count_en = clr | accept;
    count_d  = clr ? '0 : (count_q + CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (count_en) count_q <= count_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      kind_q[count_q[IW-1:0]]  <= push_kind;
      value_q[count_q[IW-1:0]] <= push_value;
      dest_q[count_q[IW-1:0]]  <= push_dest;
      iaddr_q[count_q[IW-1:0]] <= push_iaddr;
      force_q[count_q[IW-1:0]] <= push_force;
    end
  end

  always_comb begin
    count    = count_q;
    ovf      = ovf_q;
    rd_kind  = kind_q[rd_idx];
    rd_value = value_q[rd_idx];
    rd_dest  = dest_q[rd_idx];
    rd_iaddr = iaddr_q[rd_idx];
    rd_force = force_q[rd_idx];
  end
endmodule

// File: rtl/wcq_exc_filter.sv
module wcq_exc_filter
  import wcq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cap,
  input  logic               cap_fp,
  input  logic [XLEN-1:0]    cap_iaddr,
  input  logic [FMASK_W-1:0] cap_mask,
  input  logic [XLEN-1:0]    ent_iaddr,
  input  logic               ent_force,
  output logic               ent_ok
);
  logic               pend_q, pend_d, pend_en;
  logic               fp_q;
  logic [XLEN-1:0]    ia_q;
  logic [FMASK_W-1:0] mask_q;
  logic               rec_en, hit, fp_keep;

  always_comb begin
    pend_en = clr | cap;
    pend_d  = ~clr;
    rec_en  = cap & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (rec_en) begin
      fp_q   <= cap_fp;
      ia_q   <= cap_iaddr;
      mask_q <= cap_mask;
    end
  end

  always_comb begin
    hit     = pend_q & (ent_iaddr == ia_q);
    fp_keep = ~|(mask_q & ~FMASK_BENIGN);
    ent_ok  = ~hit | (fp_q ? fp_keep : ent_force);
  end
endmodule

// File: rtl/wcq_sequencer.sv
module wcq_sequencer
  import wcq_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IW   = 4,
  parameter int CW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_start,
  input  logic [XLEN-1:0] pc_in,
  input  logic            link_req,
  input  logic [CW-1:0]   count,
  input  logic [1:0]      ent_kind,
  input  logic [XLEN-1:0] ent_value,
  input  logic            ent_ok,
  output logic [IW-1:0]   rd_idx,
  output logic            ent_eff,
  output logic            idle,
  output logic            final_cyc,
  output logic [XLEN-1:0] pc_final,
  output logic            link_pending,
  output logic [XLEN-1:0] pc_cap
);
  seq_st_e         st_q, st_d;
  logic [CW-1:0]   idx_q, idx_d;
  logic            br_q, br_d;
  logic [XLEN-1:0] tgt_q, cap_q;
  logic            link_q, link_d;
  logic            drain, is_pc, is_reg, last, tgt_en, cap_en;

  always_comb begin
    idle      = (st_q == SQ_IDLE);
    drain     = (st_q == SQ_DRAIN);
    final_cyc = (st_q == SQ_FINAL);
    is_pc     = (ent_kind == WK_PC_DIRECT) || (ent_kind == WK_PC_CALC);
    is_reg    = (ent_kind == WK_REG);
    ent_eff   = drain & ent_ok & (is_reg | (is_pc & ~br_q));
    last      = (idx_q == (count - CW'(1)));

    st_d   = st_q;
    idx_d  = idx_q;
    br_d   = br_q;
    tgt_en = 1'b0;
    cap_en = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (commit_start) begin
          cap_en = 1'b1;
          br_d   = 1'b0;
          idx_d  = '0;
          st_d   = (count == '0) ? SQ_FINAL : SQ_DRAIN;
        end
      end
      SQ_DRAIN: begin
        idx_d = idx_q + CW'(1);
        if (ent_eff & is_pc) begin
          br_d   = 1'b1;
          tgt_en = 1'b1;
        end
        if (last) st_d = SQ_FINAL;
      end
      SQ_FINAL: st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase

    if (final_cyc)            link_d = 1'b0;
    else if (idle & link_req) link_d = 1'b1;
    else                      link_d = link_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      br_q   <= 1'b0;
      link_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      br_q   <= br_d;
      link_q <= link_d;
    end
  end

  always_ff @(posedge clk) begin
    if (tgt_en) tgt_q <= ent_value;
    if (cap_en) cap_q <= pc_in;
  end

  always_comb begin
    rd_idx       = idx_q[IW-1:0];
    pc_final     = br_q ? tgt_q : cap_q;
    pc_cap       = cap_q;
    link_pending = link_q;
  end
endmodule

// File: rtl/wcq_commit_queue.sv
module wcq_commit_queue
  import wcq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int XLEN  = 32,
  parameter int RW    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_start,
  input  logic               push_valid,
  input  logic [1:0]         push_kind,
  input  logic [XLEN-1:0]    push_value,
  input  logic [RW-1:0]      push_dest,
  input  logic [XLEN-1:0]    push_iaddr,
  input  logic               push_force,
  input  logic               exc_set,
  input  logic               exc_is_fp,
  input  logic [XLEN-1:0]    exc_iaddr,
  input  logic [FMASK_W-1:0] exc_mask,
  input  logic               link_req,
  input  logic               commit_start,
  input  logic [XLEN-1:0]    pc_in,
  output logic               overflow_err,
  output logic               busy,
  output logic               done,
  output logic               reg_we,
  output logic [RW-1:0]      reg_dest,
  output logic [XLEN-1:0]    reg_data,
  output logic               attr_valid,
  output logic [XLEN-1:0]    attr_pc,
  output logic               pc_we,
  output logic [XLEN-1:0]    pc_out,
  output logic               link_we,
  output logic [XLEN-1:0]    link_data
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic            idle, final_cyc, ent_ok, ent_eff, link_pending;
  logic            push_req, store_clr, exc_clr, exc_cap;
  logic [IW-1:0]   rd_idx;
  logic [CW-1:0]   count;
  logic [1:0]      ent_kind;
  logic [XLEN-1:0] ent_value, ent_iaddr, pc_final, pc_cap;
  logic [RW-1:0]   ent_dest;
  logic            ent_force;

  always_comb begin
    push_req  = push_valid & idle & ~pkt_start & ~commit_start;
    exc_clr   = pkt_start & idle;
    exc_cap   = exc_set & idle & ~pkt_start;
    store_clr = exc_clr | final_cyc;
  end

  wcq_store #(.DEPTH(DEPTH), .XLEN(XLEN), .RW(RW), .IW(IW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(store_clr), .push_req(push_req),
    .push_kind(push_kind), .push_value(push_value), .push_dest(push_dest),
    .push_iaddr(push_iaddr), .push_force(push_force), .rd_idx(rd_idx),
    .count(count), .ovf(overflow_err), .rd_kind(ent_kind), .rd_value(ent_value),
    .rd_dest(ent_dest), .rd_iaddr(ent_iaddr), .rd_force(ent_force)
  );

  wcq_exc_filter #(.XLEN(XLEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .clr(exc_clr), .cap(exc_cap), .cap_fp(exc_is_fp),
    .cap_iaddr(exc_iaddr), .cap_mask(exc_mask), .ent_iaddr(ent_iaddr),
    .ent_force(ent_force), .ent_ok(ent_ok)
  );

  wcq_sequencer #(.XLEN(XLEN), .IW(IW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .commit_start(commit_start), .pc_in(pc_in),
    .link_req(link_req), .count(count), .ent_kind(ent_kind), .ent_value(ent_value),
    .ent_ok(ent_ok), .rd_idx(rd_idx), .ent_eff(ent_eff), .idle(idle),
    .final_cyc(final_cyc), .pc_final(pc_final), .link_pending(link_pending),
    .pc_cap(pc_cap)
  );

  always_comb begin
    busy       = ~idle;
    done       = final_cyc;
    reg_we     = ent_eff & (ent_kind == WK_REG);
    reg_dest   = ent_dest;
    reg_data   = ent_value;
    attr_valid = ent_eff;
    attr_pc    = ent_iaddr;
    pc_we      = final_cyc;
    pc_out     = pc_final;
    link_we    = final_cyc & link_pending;
    link_data  = pc_cap;
  end
endmodule

// File: rtl/wcq_checker.sv
module wcq_checker (
  input logic clk,
  input logic rst_n,
  input logic push_valid,
  input logic commit_start,
  input logic overflow_err,
  input logic busy,
  input logic done,
  input logic reg_we,
  input logic link_we
);
  AST_OVF_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |-> $past(push_valid)) else $error("overflow without push"); // R10

  AST_OVF_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |-> !busy) else $error("overflow during commit"); // R10

  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_start)) else $error("busy without commit"); // R11

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy) else $error("busy after done"); // R11

  AST_REG_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (busy && !done)) else $error("register write outside drain"); // R2

  AST_LINK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (busy && !reg_we)) else $error("link write misplaced"); // R9
endmodule

bind wcq_commit_queue wcq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .commit_start(commit_start),
  .overflow_err(overflow_err), .busy(busy), .done(done), .reg_we(reg_we),
  .link_we(link_we)
);

// File: tb/sim_wcq_commit_queue.sv
`timescale 1ns/1ps
module sim_wcq_commit_queue;
  localparam int DEPTH = 16;
  localparam int XLEN  = 32;
  localparam int RW    = 5;

  logic clk, rst_n, pkt_start, push_valid, push_force, exc_set, exc_is_fp, link_req, commit_start;
  logic [1:0] push_kind;
  logic [XLEN-1:0] push_value, push_iaddr, exc_iaddr, pc_in;
  logic [RW-1:0] push_dest;
  logic [4:0] exc_mask;
  logic overflow_err, busy, done, reg_we, attr_valid, pc_we, link_we;
  logic [RW-1:0] reg_dest;
  logic [XLEN-1:0] reg_data, attr_pc, pc_out, link_data;

  wcq_commit_queue #(.DEPTH(DEPTH), .XLEN(XLEN), .RW(RW)) u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, pcyc = 0, t_commit = 0;
  bit finished = 0;
  string cur_tag = "R1";
  always @(posedge clk) pcyc = pcyc + 1;

  // bench model of the queued items
  int m_kind [DEPTH];
  logic [XLEN-1:0] m_val [DEPTH];
  logic [XLEN-1:0] m_ia [DEPTH];
  logic [RW-1:0] m_dest [DEPTH];
  bit m_force [DEPTH];
  int m_n = 0;
  bit e_pend = 0, e_fp = 0, lk = 0;
  logic [XLEN-1:0] e_ia = '0;
  logic [4:0] e_mask = '0;

  // scoreboard queues
  int q_reg_off[$]; logic [RW-1:0] q_reg_dest[$]; logic [XLEN-1:0] q_reg_data[$];
  int q_att_off[$]; logic [XLEN-1:0] q_att_ia[$];
  int q_fin_off[$]; logic [XLEN-1:0] q_fin_pc[$]; bit q_fin_lwe[$]; logic [XLEN-1:0] q_fin_ld[$];

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    int off, o;
    logic [XLEN-1:0] v;
    logic [RW-1:0] d;
    bit b;
    if (rst_n) begin
      off = pcyc - t_commit - 1;
      if (attr_valid) begin
        if (q_att_off.size() == 0) chk(cur_tag, "unexpected attribution", 1, 0);
        else begin
          o = q_att_off.pop_front(); v = q_att_ia.pop_front();
          chk(cur_tag, "attribution cycle", 64'(off), 64'(o));
          chk(cur_tag, "attr_pc", attr_pc, v);
        end
      end
      if (reg_we) begin
        if (q_reg_off.size() == 0) chk(cur_tag, "unexpected reg_we", 1, 0);
        else begin
          o = q_reg_off.pop_front(); d = q_reg_dest.pop_front(); v = q_reg_data.pop_front();
          chk(cur_tag, "reg write cycle", 64'(off), 64'(o));
          chk(cur_tag, "reg_dest", reg_dest, d);
          chk(cur_tag, "reg_data", reg_data, v);
        end
      end
      if (done) begin
        if (q_fin_off.size() == 0) chk(cur_tag, "unexpected done", 1, 0);
        else begin
          o = q_fin_off.pop_front(); v = q_fin_pc.pop_front(); b = q_fin_lwe.pop_front();
          chk(cur_tag, "done cycle", 64'(off), 64'(o));
          chk(cur_tag, "pc_we", pc_we, 1);
          chk(cur_tag, "busy at done", busy, 1);
          chk(cur_tag, "pc_out", pc_out, v);
          v = q_fin_ld.pop_front();
          chk(cur_tag, "link_we", link_we, b);
          if (b) chk(cur_tag, "link_data", link_data, v);
        end
      end else if (pc_we || link_we) chk(cur_tag, "pc/link write without done", 1, 0);
    end
  end

  task automatic do_push(input int kind, input logic [XLEN-1:0] val, input logic [RW-1:0] dest,
                         input logic [XLEN-1:0] ia, input bit frc);
    bit exp_ovf;
    @(negedge clk);
    push_valid = 1; push_kind = 2'(kind); push_value = val; push_dest = dest;
    push_iaddr = ia; push_force = frc;
    exp_ovf = (m_n == DEPTH);
    if (!exp_ovf) begin
      m_kind[m_n] = kind; m_val[m_n] = val; m_dest[m_n] = dest; m_ia[m_n] = ia;
      m_force[m_n] = frc; m_n++;
    end
    @(negedge clk);
    chk("R10", "overflow_err after push", overflow_err, exp_ovf);
    push_valid = 0;
  endtask

  task automatic do_pkt();
    @(negedge clk); pkt_start = 1;
    @(negedge clk); pkt_start = 0;
    m_n = 0; e_pend = 0;
  endtask

  task automatic do_exc(input bit fp, input logic [XLEN-1:0] ia, input logic [4:0] mask);
    @(negedge clk); exc_set = 1; exc_is_fp = fp; exc_iaddr = ia; exc_mask = mask;
    @(negedge clk); exc_set = 0;
    e_pend = 1; e_fp = fp; e_ia = ia; e_mask = mask;
  endtask

  task automatic do_link();
    @(negedge clk); link_req = 1;
    @(negedge clk); link_req = 0;
    lk = 1;
  endtask

  task automatic do_commit(input logic [XLEN-1:0] pcv, input string tag);
    bit br, ok;
    logic [XLEN-1:0] tgt;
    br = 0; tgt = '0;
    for (int i = 0; i < m_n; i++) begin
      ok = !(e_pend && m_ia[i] == e_ia) || (e_fp ? ((e_mask & ~5'b00111) == 5'b0) : m_force[i]);
      if (m_kind[i] == 3) ok = 0;
      if (ok && (m_kind[i] == 1 || m_kind[i] == 2)) begin
        if (br) ok = 0;
        else begin br = 1; tgt = m_val[i]; end
      end
      if (ok) begin q_att_off.push_back(i); q_att_ia.push_back(m_ia[i]); end
      if (ok && m_kind[i] == 0) begin
        q_reg_off.push_back(i); q_reg_dest.push_back(m_dest[i]); q_reg_data.push_back(m_val[i]);
      end
    end
    q_fin_off.push_back(m_n); q_fin_pc.push_back(br ? tgt : pcv);
    q_fin_lwe.push_back(lk); q_fin_ld.push_back(pcv);
    @(negedge clk);
    cur_tag = tag; commit_start = 1; pc_in = pcv; t_commit = pcyc;
    @(negedge clk); commit_start = 0;
    repeat (m_n + 2) @(negedge clk);
    #1;
    chk(tag, "items left unseen", 64'(q_att_off.size() + q_reg_off.size() + q_fin_off.size()), 0);
    chk(tag, "busy after commit", busy, 0);
    q_att_off.delete(); q_att_ia.delete(); q_reg_off.delete(); q_reg_dest.delete();
    q_reg_data.delete(); q_fin_off.delete(); q_fin_pc.delete(); q_fin_lwe.delete(); q_fin_ld.delete();
    m_n = 0; lk = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; pkt_start = 0; push_valid = 0; push_kind = 0; push_value = 0; push_dest = 0;
    push_iaddr = 0; push_force = 0; exc_set = 0; exc_is_fp = 0; exc_iaddr = 0; exc_mask = 0;
    link_req = 0; commit_start = 0; pc_in = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {busy, done, reg_we, attr_valid, pc_we, link_we, overflow_err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "outputs after release", {busy, done, reg_we, attr_valid, pc_we, link_we, overflow_err}, 0);

    do_commit(32'h1000, "R1 R4 R11");

    do_pkt();
    for (int i = 1; i <= 4; i++) do_push(0, 32'hA0 + i, 5'(i), 32'h100 + 4 * i, 0);
    do_commit(32'h2000, "R2 R5 R11 R4");

    do_pkt();
    do_push(0, 32'h11, 5'd7, 32'h100, 0);
    do_push(1, 32'h3000, 5'd0, 32'h104, 0);
    do_push(0, 32'h22, 5'd8, 32'h108, 0);
    do_push(2, 32'h4000, 5'd0, 32'h10c, 0);
    do_commit(32'h2100, "R3 R5");

    do_pkt();
    do_exc(0, 32'h200, 5'b0);
    do_push(0, 32'h31, 5'd1, 32'h200, 0);
    do_push(0, 32'h32, 5'd2, 32'h200, 1);
    do_push(0, 32'h33, 5'd3, 32'h204, 0);
    do_push(1, 32'h5000, 5'd0, 32'h200, 0);
    do_commit(32'h2200, "R6 R8");

    do_pkt();
    do_exc(1, 32'h300, 5'b00101);
    do_push(0, 32'h41, 5'd4, 32'h300, 0);
    do_push(2, 32'h6000, 5'd0, 32'h300, 0);
    do_commit(32'h2300, "R7");

    do_pkt();
    do_exc(1, 32'h300, 5'b01001);
    do_push(0, 32'h51, 5'd5, 32'h300, 1);
    do_push(1, 32'h7000, 5'd0, 32'h300, 0);
    do_push(1, 32'h7100, 5'd0, 32'h304, 0);
    do_push(0, 32'h52, 5'd6, 32'h304, 0);
    do_commit(32'h2400, "R7 R3 R6");

    do_pkt();
    do_link();
    do_push(0, 32'h61, 5'd9, 32'h500, 0);
    do_commit(32'h8000, "R9");
    do_pkt();
    do_push(0, 32'h62, 5'd10, 32'h504, 0);
    do_commit(32'h9000, "R9");

    do_pkt();
    for (int i = 0; i < DEPTH + 1; i++) do_push(0, 32'h700 + i, 5'(i), 32'h600 + 4 * i, 0);
    do_commit(32'hA000, "R10 R2");

    do_pkt();
    do_exc(0, 32'h400, 5'b0);
    do_push(0, 32'h81, 5'd11, 32'h400, 0);
    do_pkt();
    do_push(0, 32'h82, 5'd12, 32'h400, 0);
    do_commit(32'hB000, "R12");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule